// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single compare channel that sits beside the counter of a general-purpose timer. It receives the counter's present value, a counting-direction flag, the counter's clock-enable tick and an update-event pulse, and turns them into a registered reference waveform plus a pin-level signal that carries the selected output polarity. Software programs the channel through two write ports: one carries the compare value, the other carries the configuration word. The configuration word has a 3-bit mode, a buffer-enable bit, a polarity bit and a channel-direction field.

Eight modes are decoded. Frozen holds the level. Set-on-match and clear-on-match drive the level once, and toggle inverts it on every match. Two force modes hold the level low or high. Two complementary PWM modes take the counting direction into account. In the PWM modes the reference moves only when the comparison result flips, or on the first tick after the mode leaves frozen. The compare value can be written straight into the active register. It can also be held in a buffer and copied across on the update event, so that a new duty cycle starts on a period boundary. A nonzero direction field hands the channel to input use, and the output side then sits idle.

Top module: `oc_channel`

## Requirements
- R1: After reset the reference and the pin are low. The mode, buffer-enable, polarity and direction fields are all 0, and the compare readback is 0.
- R2: In mode 3'b000 (frozen) the reference keeps its level, including on ticks where the counter equals the compare value.
- R3: Mode 3'b001 sets the reference high and mode 3'b010 clears it low at the clock edge of a tick where the counter equals the active compare value. When no tick is present, a counter value that matches has no effect.
- R4: Mode 3'b011 inverts the reference once per tick whose counter matches the compare value. A matching count that is held while the tick is low does not invert it again.
- R5: Mode 3'b100 drives the reference low and mode 3'b101 drives it high on every clock, with no tick needed. The new level appears at the clock edge after the configuration write.
- R6: Mode 3'b110, counting up (direction input 0): a tick sets the reference high if counter < compare and low otherwise. Counting down (direction input 1): a tick sets it low if counter > compare and high otherwise.
- R7: Mode 3'b111 gives the inverse of R6. Counting up, the reference is low while counter < compare and high otherwise. Counting down, it is high when counter > compare and low otherwise.
- R8: In the PWM modes the reference changes only on a tick whose comparison result (counter < compare counting up, counter <= compare counting down) differs from the result at the previous tick. The one exception is the first tick after the mode moved from frozen into a PWM mode, which always applies the PWM level.
- R9: With buffer-enable 0, a compare write reaches the active compare value at the next clock edge, and the readback shows that value.
- R10: With buffer-enable 1, a compare write goes only into the buffer, and the readback shows the buffer. An update-event pulse copies the buffer into the active compare value at the next clock edge.
- R11: With the direction field nonzero the reference is held low, and matches and mode settings have no effect on it.
- R12: The pin equals the reference when the polarity bit is 0 and the inverted reference when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Counter clock-enable tick; match and PWM decisions occur only on it |
| cnt_val | input | CNT_W | Current counter value |
| cnt_down | input | 1 | 1 when the counter counts down |
| upd_evt | input | 1 | Update-event pulse that loads the buffered compare value |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | CNT_W | Compare value write data |
| cmp_rdata | output | CNT_W | Compare readback: the buffer when buffering is on, otherwise the active value |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Output mode field |
| cfg_buf_en | input | 1 | Compare buffering enable |
| cfg_pol | input | 1 | Output polarity, 1 inverts the pin |
| cfg_dir | input | DIR_W | Channel direction select, 0 selects output use |
| oc_ref | output | 1 | Active-high reference waveform |
| oc_pin | output | 1 | Polarity-adjusted output signal |

## Verification
The bench holds a matching count while the tick is low. A channel that compares on every clock would then set or toggle again at once, and a toggle would flip back. The bench switches into PWM from a force mode with an unchanged comparison result, so a design that tracks the comparison level instead of its flips would drop the reference too early. It also enters PWM from frozen, where a design without the entry rule would leave a stale level standing. Buffered writes are checked against a match at the new value before and after the update event, which exposes a buffer that leaks through early. The bench also checks counting down at the equality point, where swapping < and <= moves the PWM edge by one count.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [2:0] {
    OCM_FROZEN = 3'b000,
    OCM_SET    = 3'b001,
    OCM_CLR    = 3'b010,
    OCM_TOG    = 3'b011,
    OCM_FLO    = 3'b100,
    OCM_FHI    = 3'b101,
    OCM_PWM_A  = 3'b110,
    OCM_PWM_B  = 3'b111
  } oc_mode_e;

  function automatic logic mode_is_pwm(input oc_mode_e m);
    return (m == OCM_PWM_A) || (m == OCM_PWM_B);
  endfunction

  // PWM level: the PWM_A comparison flag, inverted for PWM_B
  function automatic logic pwm_level(input oc_mode_e m, input logic flag);
    return flag ^ (m == OCM_PWM_B);
  endfunction

endpackage

// File: rtl/oc_cmp_store.sv
module oc_cmp_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  input  logic             buf_en,
  input  logic             upd_evt,
  output logic [CNT_W-1:0] active_o,
  output logic [CNT_W-1:0] rdata_o
);

  logic [CNT_W-1:0] buf_q;
  logic [CNT_W-1:0] active_q;
  logic             direct_wr;
  logic             shadow_load;

  assign direct_wr   = wr_en && !buf_en;
  assign shadow_load = upd_evt && buf_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q    <= '0;
      active_q <= '0;
    end else begin
      if (wr_en)
        buf_q <= wdata;
      if (direct_wr)
        active_q <= wdata;
      else if (shadow_load)
        active_q <= buf_q;
    end
  end

  assign active_o = active_q;
  assign rdata_o  = buf_en ? buf_q : active_q;

  // R10: with buffering on and no update event, the active value is frozen
  a_r10_buffer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && !upd_evt) |=> $stable(active_o));

  // R9: an unbuffered write lands in the active value one edge later
  a_r9_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !buf_en) |=> (active_o == $past(wdata)));

endmodule

// File: rtl/oc_comparator.sv
module oc_comparator #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             down,
  output logic             eq_o,
  output logic             pwm_flag_o
);

  function automatic logic is_equal(input logic [CNT_W-1:0] a,
                                    input logic [CNT_W-1:0] b);
    return a == b;
  endfunction

  // PWM_A flag: counting up -> cnt < cmp; counting down -> not (cnt > cmp)
  function automatic logic pwm_a_flag(input logic [CNT_W-1:0] a,
                                      input logic [CNT_W-1:0] b,
                                      input logic dn);
    return dn ? !(a > b) : (a < b);
  endfunction

  assign eq_o       = is_equal(cnt, cmp);
  assign pwm_flag_o = pwm_a_flag(cnt, cmp, down);

endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  oc_mode_e mode,
  input  logic     out_en,
  input  logic     eq,
  input  logic     pwm_flag,
  output logic     ref_o
);

  logic     ref_q, ref_d;
  logic     arm_q, arm_d;
  logic     flag_last_q;
  oc_mode_e mode_last_q;

  // named events for the assertions
  logic match_evt;
  logic flip_evt;
  logic pwm_mode;
  logic entry_evt;
  logic pwm_apply;

  assign pwm_mode  = mode_is_pwm(mode);
  assign match_evt = tick && eq && out_en;
  assign flip_evt  = tick && (pwm_flag != flag_last_q);
  assign entry_evt = pwm_mode && (mode_last_q == OCM_FROZEN);
  assign pwm_apply = out_en && pwm_mode && tick && (flip_evt || arm_q || entry_evt);

  always_comb begin
    ref_d = ref_q;
    if (!out_en) begin
      ref_d = 1'b0;
    end else begin
      unique case (mode)
        OCM_FROZEN: ref_d = ref_q;
        OCM_SET:    if (match_evt) ref_d = 1'b1;
        OCM_CLR:    if (match_evt) ref_d = 1'b0;
        OCM_TOG:    if (match_evt) ref_d = !ref_q;
        OCM_FLO:    ref_d = 1'b0;
        OCM_FHI:    ref_d = 1'b1;
        OCM_PWM_A,
        OCM_PWM_B:  if (pwm_apply) ref_d = pwm_level(mode, pwm_flag);
        default:    ref_d = ref_q;
      endcase
    end
  end

  assign arm_d = out_en && pwm_mode && (arm_q || entry_evt) && !tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q       <= 1'b0;
      arm_q       <= 1'b0;
      flag_last_q <= 1'b0;
      mode_last_q <= OCM_FROZEN;
    end else begin
      ref_q       <= ref_d;
      arm_q       <= arm_d;
      mode_last_q <= mode;
      if (tick)
        flag_last_q <= pwm_flag;
    end
  end

  assign ref_o = ref_q;

  // R2: frozen mode holds the level
  a_r2_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && mode == OCM_FROZEN) |=> $stable(ref_o));

  // R3: set-on-match drives high
  a_r3_set_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && mode == OCM_SET && match_evt) |=> ref_o);

  // R3: clear-on-match drives low
  a_r3_clr_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && mode == OCM_CLR && match_evt) |=> !ref_o);

  // R4: toggle inverts once per matching tick
  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && mode == OCM_TOG && match_evt) |=> (ref_o != $past(ref_o)));

  // R4: no tick, no toggle
  a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && mode == OCM_TOG && !tick) |=> $stable(ref_o));

  // R5: force modes
  a_r5_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && mode == OCM_FLO) |=> !ref_o);
  a_r5_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && mode == OCM_FHI) |=> ref_o);

  // R8: PWM level only moves on a tick
  a_r8_pwm_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && pwm_mode && !tick) |=> $stable(ref_o));

  // R11: input use keeps the reference low
  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> !ref_o);

endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic             upd_evt,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cmp_rdata,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_buf_en,
  input  logic             cfg_pol,
  input  logic [DIR_W-1:0] cfg_dir,
  output logic             oc_ref,
  output logic             oc_pin
);

  oc_mode_e         mode_q;
  logic             buf_en_q;
  logic             pol_q;
  logic [DIR_W-1:0] dir_q;
  logic             out_en;
  logic [CNT_W-1:0] cmp_active;
  logic             cmp_eq;
  logic             cmp_flag;
  logic             ref_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= OCM_FROZEN;
      buf_en_q <= 1'b0;
      pol_q    <= 1'b0;
      dir_q    <= '0;
    end else if (cfg_wr) begin
      mode_q   <= oc_mode_e'(cfg_mode);
      buf_en_q <= cfg_buf_en;
      pol_q    <= cfg_pol;
      dir_q    <= cfg_dir;
    end
  end

  assign out_en = (dir_q == '0);

  oc_cmp_store #(.CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cmp_wr),
    .wdata    (cmp_wdata),
    .buf_en   (buf_en_q),
    .upd_evt  (upd_evt),
    .active_o (cmp_active),
    .rdata_o  (cmp_rdata)
  );

  oc_comparator #(.CNT_W(CNT_W)) u_cmp (
    .cnt        (cnt_val),
    .cmp        (cmp_active),
    .down       (cnt_down),
    .eq_o       (cmp_eq),
    .pwm_flag_o (cmp_flag)
  );

  oc_ref_gen u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (cnt_tick),
    .mode     (mode_q),
    .out_en   (out_en),
    .eq       (cmp_eq),
    .pwm_flag (cmp_flag),
    .ref_o    (ref_w)
  );

  assign oc_ref = ref_w;
  assign oc_pin = ref_w ^ pol_q;

  // R12: a polarity write alone flips the pin when the reference stays put
  a_r12_pol_flip: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(oc_ref) && $changed(pol_q)) |-> (oc_pin != $past(oc_pin)));

endmodule

// File: tb/oc_channel_tb.sv
module oc_channel_tb;

  localparam int CNT_W = 16;
  localparam int DIR_W = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cnt_tick;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_down;
  logic             upd_evt;
  logic             cmp_wr;
  logic [CNT_W-1:0] cmp_wdata;
  logic [CNT_W-1:0] cmp_rdata;
  logic             cfg_wr;
  logic [2:0]       cfg_mode;
  logic             cfg_buf_en;
  logic             cfg_pol;
  logic [DIR_W-1:0] cfg_dir;
  logic             oc_ref;
  logic             oc_pin;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DIR_W-1:0] cur_dir;
  logic             cur_pol;
  logic             cur_be;

  always #5 clk = ~clk;

  oc_channel #(.CNT_W(CNT_W), .DIR_W(DIR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
    .cnt_down(cnt_down), .upd_evt(upd_evt), .cmp_wr(cmp_wr),
    .cmp_wdata(cmp_wdata), .cmp_rdata(cmp_rdata), .cfg_wr(cfg_wr),
    .cfg_mode(cfg_mode), .cfg_buf_en(cfg_buf_en), .cfg_pol(cfg_pol),
    .cfg_dir(cfg_dir), .oc_ref(oc_ref), .oc_pin(oc_pin)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_ref(input logic exp, input string req);
    chk(oc_ref === exp, req, int'(oc_ref), int'(exp));
  endtask

  task automatic set_cfg(input logic [2:0] m, input logic be, input logic pol,
                         input logic [DIR_W-1:0] dir);
    cfg_mode = m; cfg_buf_en = be; cfg_pol = pol; cfg_dir = dir;
    cur_dir = dir; cur_pol = pol; cur_be = be;
    cfg_wr = 1'b1; step(); cfg_wr = 1'b0; step();
  endtask

  task automatic wr_cmp(input logic [CNT_W-1:0] v);
    cmp_wdata = v; cmp_wr = 1'b1; step(); cmp_wr = 1'b0;
  endtask

  task automatic tick_at(input logic [CNT_W-1:0] c, input logic dn);
    cnt_val = c; cnt_down = dn; cnt_tick = 1'b1; step(); cnt_tick = 1'b0;
  endtask

  task automatic t_reset();
    chk_ref(1'b0, "R1 ref");
    chk(oc_pin === 1'b0, "R1 pin", int'(oc_pin), 0);
    chk(cmp_rdata === '0, "R1 rdata", int'(cmp_rdata), 0);
  endtask

  task automatic t_force_pol();
    set_cfg(3'b101, 1'b0, 1'b0, '0);
    chk_ref(1'b1, "R5 force high");
    chk(oc_pin === 1'b1, "R12 pin pol0", int'(oc_pin), 1);
    set_cfg(3'b101, 1'b0, 1'b1, '0);
    chk(oc_pin === 1'b0, "R12 pin pol1", int'(oc_pin), 0);
    set_cfg(3'b100, 1'b0, 1'b1, '0);
    chk_ref(1'b0, "R5 force low");
    chk(oc_pin === 1'b1, "R12 pin pol1 low", int'(oc_pin), 1);
    set_cfg(3'b100, 1'b0, 1'b0, '0);
  endtask

  task automatic t_set_clear();
    wr_cmp(16'd5);
    chk(cmp_rdata === 16'd5, "R9 readback", int'(cmp_rdata), 5);
    set_cfg(3'b001, 1'b0, 1'b0, '0);
    tick_at(16'd4, 1'b0);
    chk_ref(1'b0, "R3 set before match");
    cnt_val = 16'd5; step(); step();
    chk_ref(1'b0, "R3 match without tick");
    tick_at(16'd5, 1'b0);
    chk_ref(1'b1, "R3 set on match");
    set_cfg(3'b010, 1'b0, 1'b0, '0);
    tick_at(16'd6, 1'b0);
    chk_ref(1'b1, "R3 clear before match");
    tick_at(16'd5, 1'b0);
    chk_ref(1'b0, "R3 clear on match");
  endtask

  task automatic t_toggle();
    set_cfg(3'b011, 1'b0, 1'b0, '0);
    tick_at(16'd5, 1'b0);
    chk_ref(1'b1, "R4 first toggle");
    cnt_val = 16'd5; step(); step();
    chk_ref(1'b1, "R4 held count no retoggle");
    tick_at(16'd6, 1'b0);
    chk_ref(1'b1, "R4 no match");
    tick_at(16'd5, 1'b0);
    chk_ref(1'b0, "R4 second toggle");
  endtask

  task automatic t_frozen();
    set_cfg(3'b101, 1'b0, 1'b0, '0);
    set_cfg(3'b000, 1'b0, 1'b0, '0);
    tick_at(16'd5, 1'b0);
    chk_ref(1'b1, "R2 frozen high at match");
    set_cfg(3'b100, 1'b0, 1'b0, '0);
    set_cfg(3'b000, 1'b0, 1'b0, '0);
    tick_at(16'd5, 1'b0);
    chk_ref(1'b0, "R2 frozen low at match");
  endtask

  task automatic t_pwm_a();
    wr_cmp(16'd4);
    set_cfg(3'b110, 1'b0, 1'b0, '0);
    tick_at(16'd0, 1'b0);
    chk_ref(1'b1, "R6 up below (R8 frozen entry)");
    tick_at(16'd3, 1'b0);
    chk_ref(1'b1, "R6 up at cmp-1");
    tick_at(16'd4, 1'b0);
    chk_ref(1'b0, "R6 up at cmp");
    tick_at(16'd7, 1'b0);
    chk_ref(1'b0, "R6 up above");
    tick_at(16'd7, 1'b1);
    chk_ref(1'b0, "R6 down above");
    tick_at(16'd4, 1'b1);
    chk_ref(1'b1, "R6 down at cmp");
  endtask

  task automatic t_pwm_b();
    set_cfg(3'b000, 1'b0, 1'b0, '0);
    set_cfg(3'b111, 1'b0, 1'b0, '0);
    tick_at(16'd2, 1'b0);
    chk_ref(1'b0, "R7 up below");
    tick_at(16'd4, 1'b0);
    chk_ref(1'b1, "R7 up at cmp");
    tick_at(16'd6, 1'b1);
    chk_ref(1'b1, "R7 down above");
    tick_at(16'd4, 1'b1);
    chk_ref(1'b0, "R7 down at cmp");
  endtask

  task automatic t_pwm_no_flip();
    set_cfg(3'b101, 1'b0, 1'b0, '0);
    tick_at(16'd6, 1'b0);
    set_cfg(3'b110, 1'b0, 1'b0, '0);
    tick_at(16'd7, 1'b0);
    chk_ref(1'b1, "R8 no flip keeps level");
    tick_at(16'd2, 1'b0);
    chk_ref(1'b1, "R8 flip to high");
    tick_at(16'd5, 1'b0);
    chk_ref(1'b0, "R8 flip to low");
  endtask

  task automatic t_buffer();
    set_cfg(3'b100, 1'b0, 1'b0, '0);
    wr_cmp(16'd3);
    set_cfg(3'b001, 1'b1, 1'b0, '0);
    wr_cmp(16'd9);
    chk(cmp_rdata === 16'd9, "R10 readback buffer", int'(cmp_rdata), 9);
    tick_at(16'd9, 1'b0);
    chk_ref(1'b0, "R10 buffer not yet active");
    upd_evt = 1'b1; step(); upd_evt = 1'b0;
    tick_at(16'd9, 1'b0);
    chk_ref(1'b1, "R10 active after update");
  endtask

  task automatic t_input_dir();
    set_cfg(3'b101, 1'b0, 1'b0, '0);
    set_cfg(3'b101, 1'b0, 1'b1, 2'd1);
    chk_ref(1'b0, "R11 idle with force high");
    chk(oc_pin === 1'b1, "R11 R12 idle pin pol1", int'(oc_pin), 1);
    wr_cmp(16'd5);
    set_cfg(3'b011, 1'b0, 1'b0, 2'd2);
    tick_at(16'd5, 1'b0);
    chk_ref(1'b0, "R11 toggle match ignored");
  endtask

  initial begin
    rst_n = 1'b0; cnt_tick = 0; cnt_val = '0; cnt_down = 0; upd_evt = 0;
    cmp_wr = 0; cmp_wdata = '0; cfg_wr = 0; cfg_mode = '0; cfg_buf_en = 0;
    cfg_pol = 0; cfg_dir = '0; cur_dir = '0; cur_pol = 0; cur_be = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_force_pol();
    t_set_clear();
    t_toggle();
    t_frozen();
    t_pwm_a();
    t_pwm_b();
    t_pwm_no_flip();
    t_buffer();
    t_input_dir();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule